// File: doc/BRIEF.md
# Flash Data-Polling Completion Controller

This block runs on the host side of a parallel flash device. It decides whether a program or erase operation that has already been launched has finished. A single-cycle start pulse hands it a polling address and the datum that the operation should leave behind. For an erase, that datum is all ones. The controller then issues status reads through a request/acknowledge read port. Each returned word is judged on two bits: the polling bit (bit 7) and the device's own time-limit flag (bit 5).

A read whose polling bit equals that of the expected datum means the operation has finished. A mismatch with the flag clear means the controller polls again. When the flag is set, the controller does not fail at once. It makes one more status read, because the polling bit can flip in the same instant as the flag. The verdict is fail only if that extra read still disagrees. After any match, the controller makes one settling read so that the lower bits have time to become valid. It then presents that complete word.

A poll-count watchdog ends an operation that never resolves. The end of every operation is a single-cycle done pulse with exactly one of pass or fail. States: `ST_IDLE`, `ST_POLL`, `ST_RECHK`, `ST_SETTLE`, `ST_DONE`. Transitions:
- IDLE→POLL on start.
- POLL→SETTLE on a match.
- POLL→RECHK on a flagged mismatch.
- POLL→POLL on a plain mismatch.
- POLL→DONE on a plain mismatch at the poll limit.
- RECHK→SETTLE on a match.
- RECHK→DONE on a mismatch.
- SETTLE→DONE when the read is acknowledged.
- DONE→IDLE unconditionally.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A start pulse sampled while idle latches the address and the expected datum. In the next cycle the block is busy and requests a read. Every read of the operation presents the latched address on `rd_addr_o`.
- R2: A read request stays high, with the same address, until the cycle in which `rd_ack_i` is high. `rd_data_i` is sampled only in that cycle.
- R3: Any status read in which bit 7 of the returned word equals bit 7 of the expected datum counts as a match. A match is followed by exactly one settling read, and then the operation ends with pass.
- R4: A status read whose bit 7 differs and whose bit 5 is 0 is followed by another status read of the same address.
- R5: A status read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one recheck read. If the recheck matches on bit 7, a settling read and pass follow. If it does not match, the operation ends with fail and `expired_o` stays 0.
- R6: When bit 7 matches and bit 5 is 1 in the same read, the match wins. No recheck read is made and the result is pass.
- R7: On pass, `data_o` holds the full word returned by the settling read. On fail, `data_o` is 0. Both stay unchanged until the next accepted start.
- R8: After MAX_POLLS status reads end in an unflagged mismatch, the block stops and reports fail with `expired_o` high. Recheck and settling reads are not counted. A flagged mismatch on the last allowed status read still gets its recheck.
- R9: `done_o` is high for exactly one cycle, the cycle after the acknowledge of the final read. While `done_o` is high, exactly one of `pass_o` and `fail_o` is high. The verdict outputs hold until the next accepted start.
- R10: A start pulse arriving while busy is ignored, including in the done cycle. The latched address and the verdict are unaffected, and no new read starts.
- R11: After reset the block is idle: no request and no done, and pass, fail, expired and data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (accepted only while idle) |
| addr_i | input | ADDR_W | Valid polling address |
| expect_i | input | DATA_W | Expected datum (all ones for erase) |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| pass_o | output | 1 | Operation completed correctly |
| fail_o | output | 1 | Operation failed |
| expired_o | output | 1 | Failure caused by the poll watchdog |
| data_o | output | DATA_W | Stable word from the settling read |

## Verification
Two functions can land on the same cycle.

The first pair is the completion test and the device's time-limit flag: one returned word can carry a matching bit 7 and a set bit 5. The bench sweeps that case next to a flagged mismatch followed by a matching recheck and by a failing recheck. It judges each case by the verdict and by the exact number of reads consumed.

The second pair is the watchdog limit and a flagged read. For every preamble length up to the limit, the flagged read is placed on the last allowed poll. The bench expects the recheck to be honoured rather than an expiry.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int STATUS_BIT = 7;
    localparam int FLAG_BIT   = 5;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_POLL   = 3'd1,
        ST_RECHK  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_DONE   = 3'd4
    } poll_state_e;

    typedef enum logic [1:0] {
        VD_MATCH   = 2'd0,
        VD_FLAGGED = 2'd1,
        VD_PENDING = 2'd2
    } poll_verdict_e;

endpackage

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
    import flash_poll_pkg::*;
(
    input  logic          status_i,
    input  logic          flag_i,
    input  logic          ref_i,
    output poll_verdict_e verdict_o
);
    // A match on the polling bit wins over the time-limit flag.
    always_comb begin
        if (status_i == ref_i) begin
            verdict_o = VD_MATCH;
        end else if (flag_i) begin
            verdict_o = VD_FLAGGED;
        end else begin
            verdict_o = VD_PENDING;
        end
    end
endmodule

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High while the status read in flight is the last one allowed.
    assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_poll_latch.sv
module flash_poll_latch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ref_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ref_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            ref_o  <= 1'b0;
        end else if (load_i) begin
            addr_o <= addr_i;
            ref_o  <= ref_i;
        end
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              expired_o,
    output logic [DATA_W-1:0] data_o
);
    poll_state_e   state_q;
    poll_state_e   state_d;
    poll_verdict_e verdict;
    logic          load;
    logic          ref_bit;
    logic          wd_last;
    logic          unused_expect_bits;

    // Only the polling bit of the expected datum takes part in the decision.
    assign unused_expect_bits = ^expect_i;

    assign load = (state_q == ST_IDLE) && start_i;

    flash_poll_latch #(
        .ADDR_W (ADDR_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .addr_i (addr_i),
        .ref_i  (expect_i[STATUS_BIT]),
        .addr_o (rd_addr_o),
        .ref_o  (ref_bit)
    );

    flash_poll_judge u_judge (
        .status_i  (rd_data_i[STATUS_BIT]),
        .flag_i    (rd_data_i[FLAG_BIT]),
        .ref_i     (ref_bit),
        .verdict_o (verdict)
    );

    flash_poll_wdog #(
        .MAX_POLLS (MAX_POLLS)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (load),
        .inc_i  ((state_q == ST_POLL) && rd_ack_i),
        .last_o (wd_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (rd_ack_i) begin
                    unique case (verdict)
                        VD_MATCH:   state_d = ST_SETTLE;
                        VD_FLAGGED: state_d = ST_RECHK;
                        default:    state_d = wd_last ? ST_DONE : ST_POLL;
                    endcase
                end
            end
            ST_RECHK: begin
                if (rd_ack_i) begin
                    state_d = (verdict == VD_MATCH) ? ST_SETTLE : ST_DONE;
                end
            end
            ST_SETTLE: begin
                if (rd_ack_i) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered verdict and data outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_o    <= 1'b0;
            fail_o    <= 1'b0;
            expired_o <= 1'b0;
            data_o    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pass_o    <= 1'b0;
                        fail_o    <= 1'b0;
                        expired_o <= 1'b0;
                        data_o    <= '0;
                    end
                end
                ST_POLL: begin
                    if (rd_ack_i && verdict == VD_PENDING && wd_last) begin
                        fail_o    <= 1'b1;
                        expired_o <= 1'b1;
                    end
                end
                ST_RECHK: begin
                    if (rd_ack_i && verdict != VD_MATCH) begin
                        fail_o <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (rd_ack_i) begin
                        pass_o <= 1'b1;
                        data_o <= rd_data_i;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign rd_req_o = (state_q == ST_POLL) || (state_q == ST_RECHK) ||
                      (state_q == ST_SETTLE);
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o,
    input logic              expired_o
);
    AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && rd_req_o)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R2

    AST_EXPIRED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> (fail_o && !pass_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o)); // R9

    AST_BUSY_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(rd_addr_o)); // R10

    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !rd_req_o)); // R10
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .expired_o (expired_o)
);

// File: tb/flash_poll_ctrl_tb.sv
`timescale 1ns/1ps
module flash_poll_ctrl_tb;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 8;
    localparam int MAX_POLLS = 4;
    localparam int SCR_N     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] expect_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              busy_o, done_o, pass_o, fail_o, expired_o;
    logic [DATA_W-1:0] data_o;

    int n_chk = 0;
    int n_err = 0;

    logic [DATA_W-1:0] script [SCR_N];
    logic [ADDR_W-1:0] cur_addr = '0;
    int                idx = 0;
    int                wcnt = 0;
    int                lat = 0;

    always #2.5 clk = ~clk;

    flash_poll_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAX_POLLS (MAX_POLLS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .addr_i    (addr_i),
        .expect_i  (expect_i),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_ack_i  (rd_ack_i),
        .rd_data_i (rd_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .fail_o    (fail_o),
        .expired_o (expired_o),
        .data_o    (data_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    // Flash model: answers each request after lat waiting cycles, from the script.
    always @(negedge clk) begin
        if (rd_ack_i) begin
            rd_ack_i = 1'b0;
        end else if (rd_req_o) begin
            if (wcnt >= lat) begin
                chk(rd_addr_o == cur_addr, "R1 read address", 32'(rd_addr_o), 32'(cur_addr));
                rd_data_i = (idx < SCR_N) ? script[idx] : 8'h00;
                rd_ack_i  = 1'b1;
                idx++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    // kind: 0 plain match, 1 flag then matching recheck, 2 flag then failing
    // recheck, 3 match with flag in same word, 4 watchdog expiry
    task automatic run_case(input logic [7:0] ex, input int n, input int kind, input int id);
        int  reads;
        bit  exp_pass;
        bit  exp_exp;
        int  cyc;
        logic [7:0] exp_data;
        for (int i = 0; i < SCR_N; i++) script[i] = ex;
        for (int i = 0; i < n; i++) script[i] = {~ex[7], ~ex[6], 1'b0, ex[4:0]};
        case (kind)
            0: begin script[n] = {ex[7], ~ex[6], 1'b0, ~ex[4:0]}; reads = n + 2; end
            3: begin script[n] = {ex[7], ~ex[6], 1'b1, ~ex[4:0]}; reads = n + 2; end
            1: begin
                script[n]   = {~ex[7], ex[6], 1'b1, ex[4:0]};
                script[n+1] = {ex[7], 7'h00};
                reads = n + 3;
            end
            2: begin
                script[n]   = {~ex[7], ex[6], 1'b1, ex[4:0]};
                script[n+1] = {~ex[7], 7'h7F};
                reads = n + 2;
            end
            default: reads = MAX_POLLS;
        endcase
        exp_pass = (kind != 2) && (kind != 4);
        exp_exp  = (kind == 4);
        exp_data = exp_pass ? ex : 8'h00;

        @(negedge clk);
        cur_addr = ADDR_W'(12'h0A0 + id);
        addr_i   = cur_addr;
        expect_i = ex;
        idx      = 0;
        wcnt     = 0;
        lat      = (n + kind) % 3;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
            start_i = (cyc == 2);
            if (cyc == 2) begin
                addr_i   = ~cur_addr;
                expect_i = ~ex;
            end
        end
        chk(done_o, "R9 done seen", 32'(done_o), 1);
        chk(pass_o == exp_pass, (kind == 3) ? "R6 match beats flag" :
            (kind == 2) ? "R5 failing recheck" : "R3 pass verdict", 32'(pass_o), 32'(exp_pass));
        chk(fail_o == !exp_pass, "R9 fail verdict", 32'(fail_o), 32'(!exp_pass));
        chk(expired_o == exp_exp, "R8 expired flag", 32'(expired_o), 32'(exp_exp));
        chk(data_o == exp_data, "R7 settled word", 32'(data_o), 32'(exp_data));
        chk(idx == reads, (kind == 4) ? "R8 read count" : "R4 read count", 32'(idx), 32'(reads));
        // start during the done cycle must be ignored
        start_i  = 1'b1;
        addr_i   = ~cur_addr;
        expect_i = ~ex;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o, "R9 done one cycle", 32'(done_o), 0);
        chk(!busy_o && !rd_req_o, "R10 start ignored", 32'({busy_o, rd_req_o}), 0);
        chk(pass_o == exp_pass && data_o == exp_data, "R10 verdict held",
            32'({pass_o, data_o}), 32'({exp_pass, exp_data}));
        @(negedge clk);
        chk(idx == reads, "R10 no extra read", 32'(idx), 32'(reads));
    endtask

    initial begin
        logic [7:0] exps [4];
        int id;
        exps[0] = 8'hFF; exps[1] = 8'h00; exps[2] = 8'h5A; exps[3] = 8'hA5;
        for (int i = 0; i < SCR_N; i++) script[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy_o && !rd_req_o && !done_o, "R11 idle in reset",
            32'({busy_o, rd_req_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pass_o && !fail_o && !expired_o && data_o == 0, "R11 cleared verdict",
            32'({pass_o, fail_o, expired_o, data_o}), 0);
        chk(!busy_o && !done_o, "R11 idle after reset", 32'({busy_o, done_o}), 0);
        id = 0;
        for (int e = 0; e < 4; e++) begin
            for (int n = 0; n < MAX_POLLS; n++) begin
                for (int k = 0; k < 4; k++) begin
                    run_case(exps[e], n, k, id);
                    id++;
                end
            end
            run_case(exps[e], MAX_POLLS, 4, id);
            id++;
        end
        finish_run();
    end
endmodule